// File: doc/BRIEF.md
# CSR Access Gate

This block stands between the instruction path that executes control-register instructions and the storage of the individual control registers. Each cycle with a valid request it takes a 12-bit register address, one of four operations (read, write, set bits, clear bits), an operand and the hart's current mode flags. It also takes three answers from an external per-address lookup: whether the register exists, whether it has a combined read-modify-write handler, and whether it has a write handler.

From these the gate decides legality in the same cycle. The top two address bits mark a read-only register. The next two bits give the lowest privilege allowed to touch it. A supervisor running with the hypervisor extension present and virtualization off is treated as one level higher. A debugger access skips only the privilege test.

Every legal request is reduced to a data word and a mask. The merged value is the old value with the masked bits replaced. A write strobe leaves the gate only when the mask is nonzero. The old value is returned as the result. Registers with a combined handler instead receive the data and mask directly. The block has no storage of its own, so it has no states: every output depends only on the present inputs.

Top module: `csr_access_gate`

## Requirements
- R1: When address bits [11:10] are both 1 the register is read-only; any request on it whose mask is nonzero raises `illegal`, while a request with a zero mask (a read, or set/clear with operand 0) is legal.
- R2: Privilege codes are 0 user, 1 supervisor, 2 hypervisor level, 3 machine. A request is illegal when the effective privilege is below address bits [9:8].
- R3: With `dbg_access` high the privilege test of R2 is skipped, but the read-only test of R1 and the existence test of R5 still apply.
- R4: With `hyp_present` high, `cur_priv` = 1 and `virt_on` low, the effective privilege is 2; with `virt_on` high or `hyp_present` low it stays 1.
- R5: A request is illegal when `reg_present` is low.
- R6: Operation codes are 0 read (mask 0), 1 write (mask all ones, data = operand), 2 set (mask = operand, data all ones), 3 clear (mask = operand, data 0); `wr_data` = (old AND NOT mask) OR (data AND mask).
- R7: `wr_en` is high only for a legal request with a nonzero mask on a register that has a write handler and no combined handler.
- R8: `rsp_data` equals `reg_rdata` in the cycle of a legal request, and is 0 when the request is illegal or no request is valid.
- R9: For a legal request on a register with a combined handler, `rmw_en` is high with `rmw_data` and `rmw_mask` set as in R6, and `wr_en` stays low.
- R10: An illegal request raises neither `wr_en` nor `rmw_en`.
- R11: A legal nonzero-mask request on a register without a write handler and without a combined handler drops the write (`wr_en` low) but still returns the old value.
- R12: With `req_valid` low, including right after reset, `illegal`, `wr_en` and `rmw_en` are low and `rsp_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used for the embedded checks |
| rst_n | input | 1 | Active-low reset for the embedded checks |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 12 | Register address |
| req_op | input | 2 | Operation code: 0 read, 1 write, 2 set, 3 clear |
| req_operand | input | XLEN | Operand of the instruction |
| cur_priv | input | 2 | Current privilege level |
| virt_on | input | 1 | Virtualization active |
| hyp_present | input | 1 | Hypervisor extension implemented |
| dbg_access | input | 1 | Request comes from the debugger |
| reg_present | input | 1 | Lookup: register exists and its extension is enabled |
| reg_has_rmw | input | 1 | Lookup: register has a combined read-modify-write handler |
| reg_has_write | input | 1 | Lookup: register has a write handler |
| reg_rdata | input | XLEN | Current value of the addressed register |
| illegal | output | 1 | Illegal-instruction indication |
| rsp_data | output | XLEN | Old value returned to the instruction |
| wr_en | output | 1 | Write strobe to register storage |
| wr_data | output | XLEN | Merged value to write |
| rmw_en | output | 1 | Strobe to the combined handler |
| rmw_data | output | XLEN | Data word for the combined handler |
| rmw_mask | output | XLEN | Mask for the combined handler |

## Verification
The gate holds no state, so a wrong decision shows at the ports in the same cycle as the request. A misread address field or a wrong privilege elevation appears as `illegal` with the wrong level for that address and mode. Such a fault can also appear as a write strobe on a request that should have been rejected. A fault in the mask forming shows as a wrong `wr_data` or `rmw_mask`, or as a strobe on a zero-mask request. The bench therefore probes each address class at the edge of its privilege threshold, and probes each operation with operands that leave some old bits untouched.

// File: rtl/csr_gate_pkg.sv
package csr_gate_pkg;
    localparam int CSR_ADDR_W = 12;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } csr_op_e;

    typedef enum logic [1:0] {
        PRIV_USER    = 2'd0,
        PRIV_SUPER   = 2'd1,
        PRIV_HYPER   = 2'd2,
        PRIV_MACHINE = 2'd3
    } priv_e;
endpackage

// File: rtl/csr_perm_check.sv
module csr_perm_check
    import csr_gate_pkg::*;
(
    input  logic [3:0] ctl_bits,
    input  priv_e      cur_priv,
    input  logic       virt_on,
    input  logic       hyp_present,
    input  logic       dbg_access,
    input  logic       reg_present,
    input  logic       mask_nz,
    output logic       deny
);
    logic  ro_reg;
    priv_e min_priv;
    priv_e eff_priv;
    logic  ro_hit;
    logic  priv_low;

    assign ro_reg   = &ctl_bits[3:2];
    assign min_priv = priv_e'(ctl_bits[1:0]);

    always_comb begin
        if (hyp_present && (cur_priv == PRIV_SUPER) && !virt_on)
            eff_priv = PRIV_HYPER;
        else
            eff_priv = cur_priv;
    end

    assign ro_hit   = ro_reg && mask_nz;
    assign priv_low = !dbg_access && (eff_priv < min_priv);
    assign deny     = ro_hit || priv_low || !reg_present;
endmodule

// File: rtl/csr_mask_form.sv
module csr_mask_form
    import csr_gate_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  csr_op_e           op,
    input  logic [XLEN-1:0]   operand,
    output logic [XLEN-1:0]   data,
    output logic [XLEN-1:0]   mask,
    output logic              mask_nz
);
    localparam logic [XLEN-1:0] ONES = {XLEN{1'b1}};

    always_comb begin
        unique case (op)
            OP_READ:  begin data = '0;      mask = '0;      end
            OP_WRITE: begin data = operand; mask = ONES;    end
            OP_SET:   begin data = ONES;    mask = operand; end
            OP_CLEAR: begin data = '0;      mask = operand; end
            default:  begin data = '0;      mask = '0;      end
        endcase
    end

    assign mask_nz = |mask;
endmodule

// File: rtl/csr_merge.sv
module csr_merge #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] data,
    input  logic [XLEN-1:0] mask,
    output logic [XLEN-1:0] new_val
);
    for (genvar b = 0; b < XLEN; b++) begin : g_bit
        assign new_val[b] = mask[b] ? data[b] : old_val[b];
    end
endmodule

// File: rtl/csr_access_gate.sv
module csr_access_gate
    import csr_gate_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [11:0]     req_addr,
    input  logic [1:0]      req_op,
    input  logic [XLEN-1:0] req_operand,
    input  logic [1:0]      cur_priv,
    input  logic            virt_on,
    input  logic            hyp_present,
    input  logic            dbg_access,
    input  logic            reg_present,
    input  logic            reg_has_rmw,
    input  logic            reg_has_write,
    input  logic [XLEN-1:0] reg_rdata,
    output logic            illegal,
    output logic [XLEN-1:0] rsp_data,
    output logic            wr_en,
    output logic [XLEN-1:0] wr_data,
    output logic            rmw_en,
    output logic [XLEN-1:0] rmw_data,
    output logic [XLEN-1:0] rmw_mask
);
    localparam int CTL_LSB = CSR_ADDR_W - 4;

    logic [XLEN-1:0] op_data;
    logic [XLEN-1:0] op_mask;
    logic            mask_nz;
    logic            deny;
    logic            grant;
    logic            unused_addr_low;

    assign unused_addr_low = ^req_addr[CTL_LSB-1:0];

    csr_mask_form #(.XLEN(XLEN)) u_form (
        .op      (csr_op_e'(req_op)),
        .operand (req_operand),
        .data    (op_data),
        .mask    (op_mask),
        .mask_nz (mask_nz)
    );

    csr_perm_check u_perm (
        .ctl_bits    (req_addr[CSR_ADDR_W-1:CTL_LSB]),
        .cur_priv    (priv_e'(cur_priv)),
        .virt_on     (virt_on),
        .hyp_present (hyp_present),
        .dbg_access  (dbg_access),
        .reg_present (reg_present),
        .mask_nz     (mask_nz),
        .deny        (deny)
    );

    csr_merge #(.XLEN(XLEN)) u_merge (
        .old_val (reg_rdata),
        .data    (op_data),
        .mask    (op_mask),
        .new_val (wr_data)
    );

    assign illegal  = req_valid && deny;
    assign grant    = req_valid && !deny;
    assign rsp_data = grant ? reg_rdata : '0;
    assign rmw_en   = grant && reg_has_rmw;
    assign rmw_data = op_data;
    assign rmw_mask = op_mask;
    assign wr_en    = grant && !reg_has_rmw && reg_has_write && mask_nz;

    assert_ro_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (&req_addr[11:10]) && (req_op == OP_WRITE)) |-> illegal);

    assert_user_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !dbg_access && (cur_priv == PRIV_USER) && (req_addr[9:8] != 2'd0)) |-> illegal);

    assert_read_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == OP_READ) |-> !wr_en);

    assert_one_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rmw_en));

    assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr_en && !rmw_en && (rsp_data == '0)));

    assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!illegal && !wr_en && !rmw_en));
endmodule

// File: tb/test_csr_access_gate.sv
module test_csr_access_gate;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [11:0]     req_addr = '0;
    logic [1:0]      req_op = '0;
    logic [XLEN-1:0] req_operand = '0;
    logic [1:0]      cur_priv = '0;
    logic            virt_on = 1'b0;
    logic            hyp_present = 1'b0;
    logic            dbg_access = 1'b0;
    logic            reg_present = 1'b0;
    logic            reg_has_rmw = 1'b0;
    logic            reg_has_write = 1'b0;
    logic [XLEN-1:0] reg_rdata = '0;
    logic            illegal;
    logic [XLEN-1:0] rsp_data;
    logic            wr_en;
    logic [XLEN-1:0] wr_data;
    logic            rmw_en;
    logic [XLEN-1:0] rmw_data;
    logic [XLEN-1:0] rmw_mask;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    csr_access_gate #(.XLEN(XLEN)) i_csr_access_gate (.*);

    task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [11:0] a, input logic [1:0] op, input logic [XLEN-1:0] opnd,
                         input logic [1:0] pv, input logic vt, input logic hy, input logic dbg,
                         input logic pres, input logic rmw, input logic wh, input logic [XLEN-1:0] old);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_op = op; req_operand = opnd;
        cur_priv = pv; virt_on = vt; hyp_present = hy; dbg_access = dbg;
        reg_present = pres; reg_has_rmw = rmw; reg_has_write = wh; reg_rdata = old;
        #1;
    endtask

    task automatic t_idle;
        @(negedge clk);
        req_valid = 1'b0; reg_rdata = 32'hDEAD_BEEF;
        #1;
        chk("R12 illegal idle", {31'b0, illegal}, 0);
        chk("R12 wr_en idle", {31'b0, wr_en}, 0);
        chk("R12 rmw_en idle", {31'b0, rmw_en}, 0);
        chk("R12 rsp idle", rsp_data, 0);
    endtask

    task automatic t_readonly;
        drive(12'hC00, 2'd1, 32'h1, 2'd3, 0, 0, 0, 1, 0, 1, 32'h55);
        chk("R1 write on ro", {31'b0, illegal}, 1);
        chk("R10 no wr on illegal", {31'b0, wr_en}, 0);
        chk("R8 rsp zero on illegal", rsp_data, 0);
        drive(12'hC00, 2'd2, 32'h0, 2'd3, 0, 0, 0, 1, 0, 1, 32'h55);
        chk("R1 set zero on ro legal", {31'b0, illegal}, 0);
        chk("R1 set zero rsp", rsp_data, 32'h55);
        drive(12'hF11, 2'd0, 32'hFFFF, 2'd3, 0, 0, 0, 1, 0, 1, 32'h77);
        chk("R1 read on ro legal", {31'b0, illegal}, 0);
        drive(12'hC01, 2'd3, 32'h4, 2'd3, 0, 0, 0, 1, 0, 1, 32'h77);
        chk("R1 clear nonzero on ro", {31'b0, illegal}, 1);
    endtask

    task automatic t_priv;
        drive(12'h300, 2'd0, 0, 2'd1, 0, 0, 0, 1, 0, 1, 32'h1);
        chk("R2 S on M reg", {31'b0, illegal}, 1);
        drive(12'h300, 2'd0, 0, 2'd3, 0, 0, 0, 1, 0, 1, 32'h1);
        chk("R2 M on M reg", {31'b0, illegal}, 0);
        drive(12'h100, 2'd0, 0, 2'd0, 0, 0, 0, 1, 0, 1, 32'h1);
        chk("R2 U on S reg", {31'b0, illegal}, 1);
        drive(12'h100, 2'd0, 0, 2'd1, 0, 0, 0, 1, 0, 1, 32'h1);
        chk("R2 S on S reg", {31'b0, illegal}, 0);
    endtask

    task automatic t_debug;
        drive(12'h300, 2'd1, 32'h9, 2'd0, 0, 0, 1, 1, 0, 1, 32'h2);
        chk("R3 dbg bypasses priv", {31'b0, illegal}, 0);
        chk("R3 dbg write goes out", {31'b0, wr_en}, 1);
        drive(12'hF11, 2'd1, 32'h9, 2'd3, 0, 0, 1, 1, 0, 1, 32'h2);
        chk("R3 dbg still ro", {31'b0, illegal}, 1);
        drive(12'h300, 2'd0, 0, 2'd3, 0, 0, 1, 0, 0, 1, 32'h2);
        chk("R3 dbg still needs present", {31'b0, illegal}, 1);
    endtask

    task automatic t_hs;
        drive(12'h200, 2'd0, 0, 2'd1, 0, 1, 0, 1, 0, 1, 32'h3);
        chk("R4 HS reaches level 2", {31'b0, illegal}, 0);
        drive(12'h200, 2'd0, 0, 2'd1, 1, 1, 0, 1, 0, 1, 32'h3);
        chk("R4 virt on no elevation", {31'b0, illegal}, 1);
        drive(12'h200, 2'd0, 0, 2'd1, 0, 0, 0, 1, 0, 1, 32'h3);
        chk("R4 no hyp no elevation", {31'b0, illegal}, 1);
        drive(12'h300, 2'd0, 0, 2'd1, 0, 1, 0, 1, 0, 1, 32'h3);
        chk("R4 HS below M", {31'b0, illegal}, 1);
    endtask

    task automatic t_present;
        drive(12'h340, 2'd0, 0, 2'd3, 0, 0, 0, 0, 0, 1, 32'h3);
        chk("R5 absent reg", {31'b0, illegal}, 1);
    endtask

    task automatic t_ops;
        logic [XLEN-1:0] old = 32'hF0F0_1234;
        drive(12'h340, 2'd1, 32'hA5A5_0000, 2'd3, 0, 0, 0, 1, 0, 1, old);
        chk("R6 write data", wr_data, 32'hA5A5_0000);
        chk("R7 write strobe", {31'b0, wr_en}, 1);
        chk("R8 write returns old", rsp_data, old);
        drive(12'h340, 2'd2, 32'h0000_00FF, 2'd3, 0, 0, 0, 1, 0, 1, old);
        chk("R6 set data", wr_data, 32'hF0F0_12FF);
        chk("R7 set strobe", {31'b0, wr_en}, 1);
        drive(12'h340, 2'd3, 32'hF000_0004, 2'd3, 0, 0, 0, 1, 0, 1, old);
        chk("R6 clear data", wr_data, 32'h00F0_1230);
        chk("R8 clear returns old", rsp_data, old);
        drive(12'h340, 2'd0, 32'hFFFF_FFFF, 2'd3, 0, 0, 0, 1, 0, 1, old);
        chk("R7 read no strobe", {31'b0, wr_en}, 0);
        chk("R8 read returns old", rsp_data, old);
        drive(12'h340, 2'd3, 32'h0, 2'd3, 0, 0, 0, 1, 0, 1, old);
        chk("R7 clear zero no strobe", {31'b0, wr_en}, 0);
    endtask

    task automatic t_rmw;
        drive(12'h344, 2'd2, 32'h8, 2'd3, 0, 0, 0, 1, 1, 1, 32'h10);
        chk("R9 rmw strobe", {31'b0, rmw_en}, 1);
        chk("R9 rmw set data", rmw_data, 32'hFFFF_FFFF);
        chk("R9 rmw set mask", rmw_mask, 32'h8);
        chk("R9 no plain write", {31'b0, wr_en}, 0);
        chk("R9 rmw returns old", rsp_data, 32'h10);
        drive(12'h344, 2'd1, 32'h55, 2'd3, 0, 0, 0, 1, 1, 1, 32'h10);
        chk("R9 rmw write data", rmw_data, 32'h55);
        chk("R9 rmw write mask", rmw_mask, 32'hFFFF_FFFF);
        drive(12'h344, 2'd3, 32'h3, 2'd3, 0, 0, 0, 1, 1, 1, 32'h10);
        chk("R9 rmw clear data", rmw_data, 32'h0);
        chk("R9 rmw clear mask", rmw_mask, 32'h3);
        drive(12'h344, 2'd1, 32'h55, 2'd1, 0, 0, 0, 1, 1, 1, 32'h10);
        chk("R10 illegal no rmw", {31'b0, rmw_en}, 0);
        chk("R10 illegal flagged", {31'b0, illegal}, 1);
    endtask

    task automatic t_nowrite;
        drive(12'h341, 2'd1, 32'h1234, 2'd3, 0, 0, 0, 1, 0, 0, 32'hCAFE);
        chk("R11 dropped write", {31'b0, wr_en}, 0);
        chk("R11 legal", {31'b0, illegal}, 0);
        chk("R11 returns old", rsp_data, 32'hCAFE);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_idle;
        @(negedge clk);
        rst_n = 1'b1;
        t_idle;
        t_readonly;
        t_priv;
        t_debug;
        t_hs;
        t_present;
        t_ops;
        t_rmw;
        t_nowrite;
        @(negedge clk);
        req_valid = 1'b0;
        t_idle;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule